// File: doc/BRIEF.md
# Speculative Load Conflict Table

This block supports code in which loads have been moved ahead of stores that might write the same bytes. When such an early load issues, the table records its destination register, its byte address, its access width and whether the access raised an exception that was held back. Every store then snoops the table. Any recorded entry whose byte range the store touches is marked with a single conflict bit.

Later, the program asks the table about a register in one of two ways. A load-check that finds a conflict asks for the load to be reissued. A branch-check that finds a conflict redirects to recovery code, which covers the case where the early value has already been used. Both forms also return the held-back exception flag.

The table is fully associative and keyed by register, with at most one entry per register. When every slot is occupied, a slot is evicted in rotating order. A register with no entry is always treated as conflicted, so losing an entry can only cause extra recovery work and never a wrong result.

Top module: `spec_load_table`

## Requirements
- R1: After reset every entry is invalid, `rspValid` is low, and any check reports a conflict.
- R2: A check issued with `chkValid` high gives its response one cycle later, with `rspValid` high for exactly that cycle. `rspRefetch` and `rspRedirect` are never both high.
- R3: A check on a register whose entry is valid and has no conflict gives `rspRefetch`=0 and `rspRedirect`=0.
- R4: A store whose byte range overlaps a valid entry's byte range sets that entry's conflict bit. A following load-check (`chkKind`=0) on that register then gives `rspRefetch`=1 and `rspRedirect`=0.
- R5: A store whose byte range only abuts an entry's range, or lies apart from it, leaves the entry unchanged.
- R6: A branch-check (`chkKind`=1) on a conflicted or missing register gives `rspRedirect`=1 and `rspRefetch`=0.
- R7: A check on a register that has no valid entry is treated as conflicted.
- R8: An advanced load to a register that already has an entry overwrites that entry in place and clears its conflict bit. After that, stores that overlap only the old range no longer affect the entry.
- R9: When an advanced load finds its register absent, it takes the lowest-index free slot. When no slot is free, it evicts the slot named by a rotating pointer. The pointer starts at 0 and advances by one, modulo the slot count, after each eviction. The evicted register then checks as conflicted.
- R10: When a store and an advanced load arrive in the same cycle, the store is compared against the entries as they stood before the load. The newly written entry starts with no conflict, while other overlapped entries are still marked.
- R11: `rspFault` equals the deferred-fault flag captured with the register's valid entry, whatever its conflict state. It is 0 when the register has no entry.
- R12: A size code k on `advSize` or `stSize` means an access of 2^k bytes (k = 0..3), covering addresses from the given address to address + 2^k - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advValid | input | 1 | Advanced load allocates an entry |
| advReg | input | REG_W | Destination register of the advanced load |
| advAddr | input | ADDR_W | Byte address of the advanced load |
| advSize | input | 2 | Size code of the advanced load (2^k bytes) |
| advFault | input | 1 | Exception deferred by the advanced load |
| stValid | input | 1 | Store snoop strobe |
| stAddr | input | ADDR_W | Byte address of the store |
| stSize | input | 2 | Size code of the store |
| chkValid | input | 1 | Check request strobe |
| chkReg | input | REG_W | Register being checked |
| chkKind | input | 1 | 0 = load-check, 1 = branch-check |
| rspValid | output | 1 | Check response valid |
| rspRefetch | output | 1 | Reissue the load |
| rspRedirect | output | 1 | Branch to recovery code |
| rspFault | output | 1 | Raise the deferred exception |

## Verification
The assertions assume that the address plus the access size never wraps past the top of the address space. They also assume each input strobe is a single-cycle pulse whose fields are meaningful only while it is high. The stimulus keeps every address far below the top of the range and drives the strobes for one cycle each. The stimulus never issues a check in the same cycle as a store or a load to the same register, so each check sees a settled table.

// File: rtl/slt_pkg.sv
package slt_pkg;

  typedef enum logic {
    CHK_LOAD   = 1'b0,
    CHK_BRANCH = 1'b1
  } chk_kind_e;

  typedef struct packed {
    logic allocEn;
    logic snoopEn;
  } slt_ctrl_t;

  function automatic logic [3:0] spanBytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/slt_datapath.sv
module slt_datapath
  import slt_pkg::*;
#(
  parameter int N      = 4,
  parameter int REG_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  slt_ctrl_t         ctrl,
  input  logic [N-1:0]      allocMask,
  input  logic [REG_W-1:0]  advReg,
  input  logic [ADDR_W-1:0] advAddr,
  input  logic [1:0]        advSize,
  input  logic              advFault,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [REG_W-1:0]  chkReg,
  output logic [N-1:0]      regHit,
  output logic [N-1:0]      freeVec,
  output logic              lkFound,
  output logic              lkConflict,
  output logic              lkFault
);

  localparam int EXT_W = ADDR_W + 1;

  logic [N-1:0]      valid;
  logic [N-1:0]      conflict;
  logic [N-1:0]      fault;
  logic [REG_W-1:0]  regId    [N];
  logic [ADDR_W-1:0] baseAddr [N];
  logic [1:0]        sizeCode [N];

  logic [N-1:0]     overlap;
  logic [EXT_W-1:0] stLo;
  logic [EXT_W-1:0] stHi;

  assign stLo = {1'b0, stAddr};
  assign stHi = stLo + EXT_W'(spanBytes(stSize)) - EXT_W'(1);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      regHit[i]  = valid[i] && (regId[i] == advReg);
      freeVec[i] = !valid[i];
      overlap[i] = valid[i]
                && (stLo <= ({1'b0, baseAddr[i]} + EXT_W'(spanBytes(sizeCode[i])) - EXT_W'(1)))
                && ({1'b0, baseAddr[i]} <= stHi);
    end
  end

  always_comb begin
    lkFound    = 1'b0;
    lkConflict = 1'b0;
    lkFault    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (valid[i] && (regId[i] == chkReg)) begin
        lkFound    = 1'b1;
        lkConflict = lkConflict | conflict[i];
        lkFault    = lkFault | fault[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid    <= '0;
      conflict <= '0;
      fault    <= '0;
      for (int i = 0; i < N; i++) begin
        regId[i]    <= '0;
        baseAddr[i] <= '0;
        sizeCode[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ctrl.allocEn && allocMask[i]) begin
          valid[i]    <= 1'b1;
          conflict[i] <= 1'b0;
          fault[i]    <= advFault;
          regId[i]    <= advReg;
          baseAddr[i] <= advAddr;
          sizeCode[i] <= advSize;
        end else if (ctrl.snoopEn && overlap[i]) begin
          conflict[i] <= 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_slotChk
    // R8 / R10: a freshly written slot is valid and clean
    a_r8_alloc_clears: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.allocEn && allocMask[i]) |=> (valid[i] && !conflict[i]));
    // R4: an overlapping store marks a slot that is not being rewritten
    a_r4_store_marks: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.snoopEn && overlap[i] && !(ctrl.allocEn && allocMask[i])) |=> conflict[i]);
    for (genvar j = i + 1; j < N; j++) begin : g_pair
      // R9: at most one entry per register
      a_r9_unique_reg: assert property (@(posedge clk) disable iff (!rstN)
        !(valid[i] && valid[j] && (regId[i] == regId[j])));
    end
  end

endmodule

// File: rtl/slt_control.sv
module slt_control
  import slt_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         advValid,
  input  logic         stValid,
  input  logic         chkValid,
  input  logic         chkKind,
  input  logic [N-1:0] regHit,
  input  logic [N-1:0] freeVec,
  input  logic         lkFound,
  input  logic         lkConflict,
  input  logic         lkFault,
  output slt_ctrl_t    ctrl,
  output logic [N-1:0] allocMask,
  output logic         rspValid,
  output logic         rspRefetch,
  output logic         rspRedirect,
  output logic         rspFault
);

  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [PTR_W-1:0] rrPtr;
  logic [N-1:0]     firstFree;
  logic             evict;
  logic             isBad;

  always_comb begin
    firstFree = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (freeVec[i]) firstFree = N'(1) << i;
    end
  end

  always_comb begin
    evict = 1'b0;
    if (|regHit)       allocMask = regHit;
    else if (|freeVec) allocMask = firstFree;
    else begin
      allocMask = N'(1) << rrPtr;
      evict     = advValid;
    end
  end

  assign ctrl.allocEn = advValid;
  assign ctrl.snoopEn = stValid;
  assign isBad        = !lkFound || lkConflict;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (evict) begin
      rrPtr <= (rrPtr == PTR_W'(N - 1)) ? '0 : rrPtr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspRefetch  <= 1'b0;
      rspRedirect <= 1'b0;
      rspFault    <= 1'b0;
    end else begin
      rspValid    <= chkValid;
      rspRefetch  <= chkValid && isBad && (chkKind == CHK_LOAD);
      rspRedirect <= chkValid && isBad && (chkKind == CHK_BRANCH);
      rspFault    <= chkValid && lkFound && lkFault;
    end
  end

  // R9: exactly one slot is chosen for every allocation
  a_r9_alloc_onehot: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.allocEn |-> $onehot(allocMask));
  // R2: response follows the request by one cycle
  a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> rspValid);
  a_r2_rsp_only_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> !rspValid);
  // R2: refetch and redirect are exclusive
  a_r2_rsp_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rspRefetch && rspRedirect));
  // R11: no flag without a response
  a_r11_flags_need_valid: assert property (@(posedge clk) disable iff (!rstN)
    (rspRefetch || rspRedirect || rspFault) |-> rspValid);

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int N      = 4,
  parameter int REG_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advValid,
  input  logic [REG_W-1:0]  advReg,
  input  logic [ADDR_W-1:0] advAddr,
  input  logic [1:0]        advSize,
  input  logic              advFault,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic              chkValid,
  input  logic [REG_W-1:0]  chkReg,
  input  logic              chkKind,
  output logic              rspValid,
  output logic              rspRefetch,
  output logic              rspRedirect,
  output logic              rspFault
);

  slt_ctrl_t    ctrl;
  logic [N-1:0] allocMask;
  logic [N-1:0] regHit;
  logic [N-1:0] freeVec;
  logic         lkFound;
  logic         lkConflict;
  logic         lkFault;

  slt_control #(.N(N)) i_ctrl (
    .clk(clk), .rstN(rst_n),
    .advValid(advValid), .stValid(stValid),
    .chkValid(chkValid), .chkKind(chkKind),
    .regHit(regHit), .freeVec(freeVec),
    .lkFound(lkFound), .lkConflict(lkConflict), .lkFault(lkFault),
    .ctrl(ctrl), .allocMask(allocMask),
    .rspValid(rspValid), .rspRefetch(rspRefetch),
    .rspRedirect(rspRedirect), .rspFault(rspFault)
  );

  slt_datapath #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rst_n),
    .ctrl(ctrl), .allocMask(allocMask),
    .advReg(advReg), .advAddr(advAddr), .advSize(advSize), .advFault(advFault),
    .stAddr(stAddr), .stSize(stSize),
    .chkReg(chkReg),
    .regHit(regHit), .freeVec(freeVec),
    .lkFound(lkFound), .lkConflict(lkConflict), .lkFault(lkFault)
  );

endmodule

// File: tb/test_spec_load_table.sv
`timescale 1ns/1ps
module test_spec_load_table;

  localparam int N = 4, REG_W = 6, ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic advValid = 0, advFault = 0, stValid = 0, chkValid = 0, chkKind = 0;
  logic [REG_W-1:0]  advReg = '0, chkReg = '0;
  logic [ADDR_W-1:0] advAddr = '0, stAddr = '0;
  logic [1:0]        advSize = '0, stSize = '0;
  logic rspValid, rspRefetch, rspRedirect, rspFault;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct packed {logic refetch; logic redirect; logic flt;} exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  spec_load_table #(.N(N), .REG_W(REG_W), .ADDR_W(ADDR_W)) i_spec_load_table (
    .clk(clk), .rst_n(rst_n),
    .advValid(advValid), .advReg(advReg), .advAddr(advAddr), .advSize(advSize), .advFault(advFault),
    .stValid(stValid), .stAddr(stAddr), .stSize(stSize),
    .chkValid(chkValid), .chkReg(chkReg), .chkKind(chkKind),
    .rspValid(rspValid), .rspRefetch(rspRefetch), .rspRedirect(rspRedirect), .rspFault(rspFault)
  );

  task automatic advLoad(input int r, input int a, input int sz, input bit f);
    advValid = 1; advReg = REG_W'(r); advAddr = ADDR_W'(a); advSize = 2'(sz); advFault = f;
    @(negedge clk);
    advValid = 0; advFault = 0;
  endtask

  task automatic doStore(input int a, input int sz);
    stValid = 1; stAddr = ADDR_W'(a); stSize = 2'(sz);
    @(negedge clk);
    stValid = 0;
  endtask

  task automatic loadAndStore(input int r, input int a, input int sz, input int sa, input int ssz);
    advValid = 1; advReg = REG_W'(r); advAddr = ADDR_W'(a); advSize = 2'(sz); advFault = 0;
    stValid = 1; stAddr = ADDR_W'(sa); stSize = 2'(ssz);
    @(negedge clk);
    advValid = 0; stValid = 0;
  endtask

  task automatic doCheck(input int r, input bit kind, input bit eRef, input bit eRed,
                         input bit eFlt, input string tag);
    exp_t e;
    e.refetch = eRef; e.redirect = eRed; e.flt = eFlt;
    expQ.push_back(e);
    tagQ.push_back(tag);
    chkValid = 1; chkReg = REG_W'(r); chkKind = kind;
    @(negedge clk);
    chkValid = 0;
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected response: actual rspValid=1 expected rspValid=0");
      end else begin
        exp_t  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({rspRefetch, rspRedirect, rspFault} !== {e.refetch, e.redirect, e.flt}) begin
          failures++;
          $display("FAIL %s: actual refetch/redirect/fault=%b%b%b expected=%b%b%b",
                   t, rspRefetch, rspRedirect, rspFault, e.refetch, e.redirect, e.flt);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (rspValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: actual rspValid=%b expected 0", rspValid);
    end
    // R1 / R7: empty table checks as conflicted
    doCheck(7, 0, 1, 0, 0, "R1 empty load-check");
    doCheck(7, 1, 0, 1, 0, "R7 empty branch-check");
    // R3: clean entry
    advLoad(1, 'h100, 2, 0);
    doCheck(1, 0, 0, 0, 0, "R3 clean load-check");
    // R5: abutting stores on both sides
    doStore('h104, 0);
    doStore('h0FC, 2);
    doCheck(1, 0, 0, 0, 0, "R5 abutting stores ignored");
    doCheck(1, 1, 0, 0, 0, "R5 branch-check stays clean");
    // R4 / R6: overlap on last byte
    doStore('h103, 0);
    doCheck(1, 0, 1, 0, 0, "R4 overlap refetch");
    doCheck(1, 1, 0, 1, 0, "R6 overlap redirect");
    // R12: 8-byte store reaches a 1-byte entry
    advLoad(2, 'h200, 0, 0);
    doStore('h1F8, 3);
    doCheck(2, 0, 0, 0, 0, "R12 8-byte store below ends at 0x1FF");
    doStore('h1FC, 3);
    doCheck(2, 1, 0, 1, 0, "R12 8-byte store covers 0x200");
    // R8: reallocation clears and moves the range
    advLoad(1, 'h300, 1, 0);
    doCheck(1, 0, 0, 0, 0, "R8 realloc clears conflict");
    doStore('h100, 2);
    doCheck(1, 0, 0, 0, 0, "R8 old range no longer tracked");
    // R11: deferred fault
    advLoad(3, 'h400, 0, 1);
    doCheck(3, 0, 0, 0, 1, "R11 fault on clean entry");
    doCheck(9, 1, 0, 1, 0, "R11 no fault without entry");
    // R10: simultaneous alloc and store
    loadAndStore(4, 'h300, 1, 'h300, 0);
    doCheck(4, 0, 0, 0, 0, "R10 new entry not conflicted");
    doCheck(1, 0, 1, 0, 0, "R10 existing entry still marked");
    // R9: table full (regs 1,2,3,4 in slots 0..3); rotate evictions
    advLoad(5, 'h600, 2, 0);
    advLoad(6, 'h700, 2, 0);
    doCheck(1, 0, 1, 0, 0, "R9 first eviction hits slot0");
    doCheck(2, 1, 0, 1, 0, "R9 second eviction hits slot1");
    doCheck(3, 0, 0, 0, 1, "R9 slot2 survives");
    doCheck(5, 0, 0, 0, 0, "R9 new reg5 clean");
    doCheck(6, 0, 0, 0, 0, "R9 new reg6 clean");
    doCheck(4, 0, 0, 0, 0, "R9 slot3 survives");
    advLoad(7, 'h800, 0, 0);
    doCheck(3, 0, 1, 0, 0, "R9 third eviction hits slot2");
    doCheck(7, 1, 0, 0, 0, "R9 new reg7 clean");
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2 missing responses: actual pending=%0d expected 0", expQ.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule